// File: doc/BRIEF.md
# Prioritized Region Memory Protection Checker

This block decides, for every memory access, whether the access may proceed. It holds a table of programmable regions. Each region has a base address, a power-of-two size, an enable bit, four permission bits, an execute-never bit, a memory type and a shared flag. Regions may overlap. When several regions contain an address, the region with the highest index decides the outcome.

Two lookup ports share the one table and work independently in the same cycle. The data port serves loads and stores. The fetch port serves instruction prefetches. Each port returns a registered response one cycle after its request. The response carries a permit flag, a fault code, the index of the matching region, the memory type and the shared flag.

There are two kinds of fault. An address that lies in no enabled region raises a background fault. An address whose region forbids the access raises a permission fault. The region table is loaded through a write port that replaces one whole region entry per clock cycle.

Top module: `mpu_prio_guard`

## Requirements
- R1: After reset, every region is disabled and both response-valid outputs are low. An access made right after reset therefore raises a background fault.
- R2: A write with `cfg_we` high stores the whole entry into region `cfg_idx` at the clock edge. Lookups requested in any later cycle use the new entry.
- R3: A region with size code N covers 2^(N+1) bytes. Only the address bits above bit N are compared against the base. Size codes below 4 are treated as 4, which gives 32 bytes. Code 31 covers the whole 32-bit space.
- R4: A region whose enable bit is 0 never matches, even when it holds the highest index.
- R5: When several enabled regions contain the address, the region with the highest index supplies the permissions, the attributes and the reported region index.
- R6: When no enabled region contains the address, the response gives fault code 2'b01 (background), permit 0, region index 0, memory type 2'b00 and shared 0.
- R7: The 4-bit permission field is laid out as follows: bit0 allows privileged read, bit1 privileged write, bit2 user read and bit3 user write. A data access that its region forbids gives fault code 2'b10 (permission), permit 0 and the region's index. An allowed access gives fault code 2'b00 and permit 1.
- R8: An instruction fetch is allowed only if the region grants read permission at the fetch's privilege level and its execute-never bit is 0. Otherwise the fetch gives fault code 2'b10. Execute-never does not affect data reads.
- R9: The memory type is encoded as 2'b00 uncached, 2'b01 cacheable and 2'b10 device. The type and the shared flag of the selected region are reported on a permit and also on a permission fault.
- R10: Each port raises its response-valid output in the cycle after a request, and only then. The two ports can be used in the same cycle, and each gives its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | 4 | Index of the region being written |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code N, giving 2^(N+1) bytes |
| cfg_en | input | 1 | Region enable |
| cfg_perm | input | 4 | Permission bits: privileged read, privileged write, user read, user write (bit0 to bit3) |
| cfg_xn | input | 1 | Execute-never |
| cfg_mtype | input | 2 | Memory type: 00 uncached, 01 cacheable, 10 device |
| cfg_shared | input | 1 | Shared attribute |
| ls_req | input | 1 | Data access request |
| ls_addr | input | 32 | Data access address |
| ls_write | input | 1 | Data access is a write |
| ls_priv | input | 1 | Data access is privileged |
| ls_rsp_valid | output | 1 | Data response valid |
| ls_permit | output | 1 | Data access permitted |
| ls_fault | output | 2 | Data fault code: 00 none, 01 background, 10 permission |
| ls_region | output | 4 | Selected region index for the data access |
| ls_mtype | output | 2 | Memory type for the data access |
| ls_shared | output | 1 | Shared flag for the data access |
| pf_req | input | 1 | Fetch request |
| pf_addr | input | 32 | Fetch address |
| pf_priv | input | 1 | Fetch is privileged |
| pf_rsp_valid | output | 1 | Fetch response valid |
| pf_permit | output | 1 | Fetch permitted |
| pf_fault | output | 2 | Fetch fault code |
| pf_region | output | 4 | Selected region index for the fetch |
| pf_mtype | output | 2 | Memory type for the fetch |
| pf_shared | output | 1 | Shared flag for the fetch |

## Verification
The hardest case to reach is an address covered by three layers at once. The layers are a large low-index region, a smaller higher-index region nested inside it, and a disabled region with an even higher index over the same range. The chosen entry must change as the address moves out of the nested window. The bench builds this layout one region at a time through the write port. It then probes addresses inside the nested window, addresses in the outer region only, and addresses just past each boundary. This shows that priority, enable gating and the size mask interact correctly. Last of all, it enables a top-index region that covers the whole address space. This gives one more priority check, and it confirms that size code 31 covers every address.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned SIZE_W = 5;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_BG   = 2'b01,
    FLT_PERM = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    MT_UNCACHED  = 2'b00,
    MT_CACHEABLE = 2'b01,
    MT_DEVICE    = 2'b10
  } mtype_e;

  typedef struct packed {
    logic               en;
    logic [ADDR_W-1:0]  base;
    logic [SIZE_W-1:0]  size;
    logic [3:0]         perm;
    logic               xn;
    logic [1:0]         mtype;
    logic               shared;
  } region_t;
endpackage

// File: rtl/mpu_region_table.sv
module mpu_region_table
  import mpu_pkg::*;
#(
  parameter int unsigned NREG = 16,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDXW-1:0]   idx_i,
  input  region_t           ent_i,
  output region_t           regs_o [NREG]
);
  region_t regs_q [NREG];
  region_t regs_d [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
      if (we_i && (idx_i == IDXW'(i))) regs_d[i] = ent_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign regs_o = regs_q;

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (regs_q[$past(idx_i)] == $past(ent_i)));
endmodule

// File: rtl/mpu_lookup.sv
module mpu_lookup
  import mpu_pkg::*;
#(
  parameter int unsigned NREG = 16,
  localparam int unsigned IDXW = $clog2(NREG),
  localparam int unsigned MIN_SZ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  region_t           regs_i [NREG],
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              priv_i,
  input  logic              fetch_i,
  output logic              rsp_valid_o,
  output logic              permit_o,
  output logic [1:0]        fault_o,
  output logic [IDXW-1:0]   region_o,
  output logic [1:0]        mtype_o,
  output logic              shared_o
);
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_match
    logic [SIZE_W-1:0] sz_eff;
    logic [ADDR_W-1:0] care;
    always_comb begin
      sz_eff = (regs_i[g].size < SIZE_W'(MIN_SZ)) ? SIZE_W'(MIN_SZ) : regs_i[g].size;
      care   = {ADDR_W{1'b1}} << ({1'b0, sz_eff} + 6'd1);
    end
    assign hit[g] = regs_i[g].en && (((addr_i ^ regs_i[g].base) & care) == '0);
  end

  logic            any_d;
  logic [IDXW-1:0] sel_d;
  region_t         ent;
  logic            rd_ok, wr_ok, allow;
  logic            permit_d, shared_d;
  logic [1:0]      fault_d, mtype_d;
  logic [IDXW-1:0] region_d;

  always_comb begin
    any_d = 1'b0;
    sel_d = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        any_d = 1'b1;
        sel_d = IDXW'(i);
      end
    end
    ent   = regs_i[sel_d];
    rd_ok = priv_i ? ent.perm[0] : ent.perm[2];
    wr_ok = priv_i ? ent.perm[1] : ent.perm[3];
    if (fetch_i) allow = rd_ok && !ent.xn;
    else         allow = write_i ? wr_ok : rd_ok;

    if (!any_d) begin
      permit_d = 1'b0;
      fault_d  = FLT_BG;
      region_d = '0;
      mtype_d  = MT_UNCACHED;
      shared_d = 1'b0;
    end else begin
      permit_d = allow;
      fault_d  = allow ? FLT_NONE : FLT_PERM;
      region_d = sel_d;
      mtype_d  = ent.mtype;
      shared_d = ent.shared;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      permit_o    <= 1'b0;
      fault_o     <= FLT_NONE;
      region_o    <= '0;
      mtype_o     <= MT_UNCACHED;
      shared_o    <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        permit_o <= permit_d;
        fault_o  <= fault_d;
        region_o <= region_d;
        mtype_o  <= mtype_d;
        shared_o <= shared_d;
      end
    end
  end

  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rsp_valid_o);
  p_no_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !rsp_valid_o);
  p_bg_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && fault_o == FLT_BG) |-> (!permit_o && region_o == '0 && mtype_o == MT_UNCACHED && !shared_o));
  p_fault_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> ($onehot0(fault_o) && (permit_o == (fault_o == FLT_NONE))));
  p_disabled_never_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_d && req_i) |=> (fault_o != FLT_BG));
endmodule

// File: rtl/mpu_prio_guard.sv
module mpu_prio_guard
  import mpu_pkg::*;
#(
  parameter int unsigned NREG = 16,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [31:0]       cfg_base,
  input  logic [4:0]        cfg_size,
  input  logic              cfg_en,
  input  logic [3:0]        cfg_perm,
  input  logic              cfg_xn,
  input  logic [1:0]        cfg_mtype,
  input  logic              cfg_shared,
  input  logic              ls_req,
  input  logic [31:0]       ls_addr,
  input  logic              ls_write,
  input  logic              ls_priv,
  output logic              ls_rsp_valid,
  output logic              ls_permit,
  output logic [1:0]        ls_fault,
  output logic [IDXW-1:0]   ls_region,
  output logic [1:0]        ls_mtype,
  output logic              ls_shared,
  input  logic              pf_req,
  input  logic [31:0]       pf_addr,
  input  logic              pf_priv,
  output logic              pf_rsp_valid,
  output logic              pf_permit,
  output logic [1:0]        pf_fault,
  output logic [IDXW-1:0]   pf_region,
  output logic [1:0]        pf_mtype,
  output logic              pf_shared
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  region_t ent_w;
  region_t regs [NREG];

  assign ent_w = '{en: cfg_en, base: cfg_base, size: cfg_size, perm: cfg_perm,
                   xn: cfg_xn, mtype: cfg_mtype, shared: cfg_shared};

  mpu_region_table #(.NREG(NREG)) table_i (
    .clk(clk), .rst_n(rst_n_s), .we_i(cfg_we), .idx_i(cfg_idx),
    .ent_i(ent_w), .regs_o(regs)
  );

  mpu_lookup #(.NREG(NREG)) ls_look_i (
    .clk(clk), .rst_n(rst_n_s), .regs_i(regs),
    .req_i(ls_req), .addr_i(ls_addr), .write_i(ls_write), .priv_i(ls_priv), .fetch_i(1'b0),
    .rsp_valid_o(ls_rsp_valid), .permit_o(ls_permit), .fault_o(ls_fault),
    .region_o(ls_region), .mtype_o(ls_mtype), .shared_o(ls_shared)
  );

  mpu_lookup #(.NREG(NREG)) pf_look_i (
    .clk(clk), .rst_n(rst_n_s), .regs_i(regs),
    .req_i(pf_req), .addr_i(pf_addr), .write_i(1'b0), .priv_i(pf_priv), .fetch_i(1'b1),
    .rsp_valid_o(pf_rsp_valid), .permit_o(pf_permit), .fault_o(pf_fault),
    .region_o(pf_region), .mtype_o(pf_mtype), .shared_o(pf_shared)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (!ls_rsp_valid && !pf_rsp_valid));
endmodule

// File: tb/mpu_prio_guard_tb_top.sv
module mpu_prio_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we; logic [3:0] cfg_idx; logic [31:0] cfg_base; logic [4:0] cfg_size;
  logic cfg_en; logic [3:0] cfg_perm; logic cfg_xn; logic [1:0] cfg_mtype; logic cfg_shared;
  logic ls_req; logic [31:0] ls_addr; logic ls_write; logic ls_priv;
  logic ls_rsp_valid, ls_permit, ls_shared; logic [1:0] ls_fault, ls_mtype; logic [3:0] ls_region;
  logic pf_req; logic [31:0] pf_addr; logic pf_priv;
  logic pf_rsp_valid, pf_permit, pf_shared; logic [1:0] pf_fault, pf_mtype; logic [3:0] pf_region;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  mpu_prio_guard dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] rsp(logic p, logic [1:0] f, logic [3:0] r, logic [1:0] m, logic s);
    return {p, f, r, m, s};
  endfunction

  task automatic wr_region(logic [3:0] idx, logic [31:0] base, logic [4:0] sz, logic en,
                           logic [3:0] perm, logic xn, logic [1:0] mt, logic sh);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_base = base; cfg_size = sz; cfg_en = en;
    cfg_perm = perm; cfg_xn = xn; cfg_mtype = mt; cfg_shared = sh;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic data_acc(string tag, logic [31:0] a, logic w, logic pv, logic [9:0] exp);
    @(negedge clk);
    ls_req = 1; ls_addr = a; ls_write = w; ls_priv = pv;
    @(negedge clk);
    ls_req = 0;
    chk({tag, " valid"}, 32'(ls_rsp_valid), 32'd1);
    chk(tag, 32'({ls_permit, ls_fault, ls_region, ls_mtype, ls_shared}), 32'(exp));
  endtask

  task automatic fetch_acc(string tag, logic [31:0] a, logic pv, logic [9:0] exp);
    @(negedge clk);
    pf_req = 1; pf_addr = a; pf_priv = pv;
    @(negedge clk);
    pf_req = 0;
    chk({tag, " valid"}, 32'(pf_rsp_valid), 32'd1);
    chk(tag, 32'({pf_permit, pf_fault, pf_region, pf_mtype, pf_shared}), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R1 ls idle", 32'(ls_rsp_valid), 0);
    chk("R1 pf idle", 32'(pf_rsp_valid), 0);
    data_acc("R1 R6 empty table", 32'h0000_1000, 0, 1, rsp(0, 2'b01, 0, 0, 0));
    @(negedge clk);
    chk("R10 valid drops", 32'(ls_rsp_valid), 0);
  endtask

  task automatic t_basic();
    wr_region(0, 32'h0000_1000, 5'd11, 1, 4'b1111, 0, 2'b01, 1);
    data_acc("R2 R9 inside", 32'h0000_1FFC, 0, 0, rsp(1, 0, 0, 2'b01, 1));
    data_acc("R3 first byte", 32'h0000_1000, 1, 1, rsp(1, 0, 0, 2'b01, 1));
    data_acc("R3 R6 past end", 32'h0000_2000, 0, 1, rsp(0, 2'b01, 0, 0, 0));
    data_acc("R3 below base", 32'h0000_0FFF, 0, 1, rsp(0, 2'b01, 0, 0, 0));
  endtask

  task automatic t_clamp();
    wr_region(1, 32'h0000_8000, 5'd2, 1, 4'b1111, 0, 2'b00, 0);
    data_acc("R3 clamp last", 32'h0000_801F, 0, 1, rsp(1, 0, 1, 0, 0));
    data_acc("R3 clamp beyond", 32'h0000_8020, 0, 1, rsp(0, 2'b01, 0, 0, 0));
  endtask

  task automatic t_layers();
    wr_region(5, 32'h0000_1800, 5'd7, 1, 4'b0001, 0, 2'b10, 0);
    wr_region(9, 32'h0000_1000, 5'd11, 0, 4'b0000, 1, 2'b00, 0);
    data_acc("R5 nested priv rd", 32'h0000_1810, 0, 1, rsp(1, 0, 5, 2'b10, 0));
    data_acc("R7 R9 user rd abort", 32'h0000_1810, 0, 0, rsp(0, 2'b10, 5, 2'b10, 0));
    data_acc("R7 priv wr abort", 32'h0000_18FF, 1, 1, rsp(0, 2'b10, 5, 2'b10, 0));
    data_acc("R5 outside nested", 32'h0000_1900, 1, 0, rsp(1, 0, 0, 2'b01, 1));
    data_acc("R4 disabled top", 32'h0000_1004, 1, 0, rsp(1, 0, 0, 2'b01, 1));
  endtask

  task automatic t_perm();
    wr_region(3, 32'h0000_4000, 5'd9, 1, 4'b0110, 0, 2'b01, 0);
    data_acc("R7 priv rd no", 32'h0000_4100, 0, 1, rsp(0, 2'b10, 3, 2'b01, 0));
    data_acc("R7 priv wr ok", 32'h0000_4100, 1, 1, rsp(1, 0, 3, 2'b01, 0));
    data_acc("R7 user rd ok", 32'h0000_43FF, 0, 0, rsp(1, 0, 3, 2'b01, 0));
    data_acc("R7 user wr no", 32'h0000_43FF, 1, 0, rsp(0, 2'b10, 3, 2'b01, 0));
  endtask

  task automatic t_fetch();
    fetch_acc("R8 priv fetch no rd", 32'h0000_4000, 1, rsp(0, 2'b10, 3, 2'b01, 0));
    fetch_acc("R8 user fetch ok", 32'h0000_4000, 0, rsp(1, 0, 3, 2'b01, 0));
    wr_region(3, 32'h0000_4000, 5'd9, 1, 4'b0110, 1, 2'b01, 0);
    fetch_acc("R8 xn fetch", 32'h0000_4000, 0, rsp(0, 2'b10, 3, 2'b01, 0));
    data_acc("R8 xn data rd", 32'h0000_4000, 0, 0, rsp(1, 0, 3, 2'b01, 0));
    fetch_acc("R6 fetch bg", 32'h0009_0000, 1, rsp(0, 2'b01, 0, 0, 0));
  endtask

  task automatic t_dual();
    @(negedge clk);
    ls_req = 1; ls_addr = 32'h0000_1810; ls_write = 0; ls_priv = 1;
    pf_req = 1; pf_addr = 32'h0000_1900; pf_priv = 1;
    @(negedge clk);
    ls_req = 0; pf_req = 0;
    chk("R10 both valid", 32'({ls_rsp_valid, pf_rsp_valid}), 32'b11);
    chk("R10 ls result", 32'({ls_permit, ls_fault, ls_region, ls_mtype, ls_shared}), 32'(rsp(1, 0, 5, 2'b10, 0)));
    chk("R10 pf result", 32'({pf_permit, pf_fault, pf_region, pf_mtype, pf_shared}), 32'(rsp(1, 0, 0, 2'b01, 1)));
  endtask

  task automatic t_whole();
    wr_region(15, 32'h0000_0000, 5'd31, 1, 4'b0100, 0, 2'b00, 1);
    data_acc("R3 full space user", 32'hFFFF_FFF0, 0, 0, rsp(1, 0, 15, 0, 1));
    data_acc("R5 top wins priv", 32'h0000_1810, 0, 1, rsp(0, 2'b10, 15, 0, 1));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_size = 0; cfg_en = 0;
    cfg_perm = 0; cfg_xn = 0; cfg_mtype = 0; cfg_shared = 0;
    ls_req = 0; ls_addr = 0; ls_write = 0; ls_priv = 0;
    pf_req = 0; pf_addr = 0; pf_priv = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_clamp();
    t_layers();
    t_perm();
    t_fetch();
    t_dual();
    t_whole();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule